// File: doc/BRIEF.md
# Timer clock source selector

This block creates the count-enable that advances a timer. The timer runs on the system clock, and it moves forward only in a cycle where this block raises its enable for one clock. A 3-bit selector picks where that enable comes from. The choices are:

- no source at all, so the timer holds still;
- every system clock;
- one of four power-of-two divisions taken from a shared free-running 10-bit prescaler;
- edges on an external pin, counted on either the rising or the falling edge.

The external pin is asynchronous. It passes through a synchroniser and then an edge detector, and each qualifying edge gives exactly one enable pulse. Edges count whether or not the pin is also being driven as an output elsewhere in the chip. A synchronous clear input zeroes the prescaler, which gives the divided pulses a known phase.

Top module: `tmr_clk_sel`

## Requirements
- R1: With `src_sel` = 3'b000 no enable pulse is produced, for as long as that selection is held.
- R2: With `src_sel` = 3'b001 `tick` is high in every cycle, starting one clock after the selection is applied.
- R3: With `src_sel` = 3'b010 a pulse comes every 8 clocks, and with 3'b011 every 32 clocks.
- R4: With `src_sel` = 3'b100 a pulse comes every 256 clocks, and with 3'b101 every 1024 clocks.
- R5: For a divide-by-N selection, the first pulse after a `presc_clr` clock edge is seen in the Nth cycle after that edge. Every divided pulse lasts exactly one clock.
- R6: With `src_sel` = 3'b111, each rising edge on `ext_pin` gives exactly one one-clock pulse. The pulse is high in the third cycle after the first clock edge that sees the new pin level.
- R7: With `src_sel` = 3'b110, each falling edge on `ext_pin` gives exactly one pulse, with the same three-clock latency.
- R8: In the external modes, the edge of the opposite polarity is ignored. A prescaler clear or prescaler rollover also produces no pulse in those modes.
- R9: While `rst_n` is low, `tick` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_clr | input | 1 | Synchronous clear of the free-running prescaler |
| src_sel | input | 3 | Enable source: stop, /1, /8, /32, /256, /1024, pin falling, pin rising |
| ext_pin | input | 1 | Asynchronous external count input |
| tick | output | 1 | One-cycle count enable for the timer |

## Verification
Each prescaled selection is applied right after a prescaler clear, and the bench checks two things: the pulse count in a fixed window and the position of the first pulse. Together these separate a wrong tap from a wrong rollover phase. The external modes are tried three ways:

- single transitions in each polarity, to pin down the exact three-cycle latency and show that the opposite edge is ignored;
- a burst of ten square-wave periods, to show one pulse per edge with none lost or doubled;
- a long static pin with prescaler clears, to show the prescaler cannot leak into the external path.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    SRC_OFF      = 3'd0,
    SRC_DIV1     = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV32    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_EXT_FALL = 3'd6,
    SRC_EXT_RISE = 3'd7
  } src_sel_e;

  localparam int NUM_TAPS = 4;

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int CNT_W = 10,
  parameter int NUM_TAPS = 4,
  parameter int TAP_LOG [NUM_TAPS] = '{3, 5, 8, 10}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  output logic [NUM_TAPS-1:0] roll
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  // A tap is about to roll when its low bits are all ones.
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign roll[i] = &cnt_q[TAP_LOG[i]-1:0];
  end

endmodule

// File: rtl/tcs_ext_edge.sv
module tcs_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      hist_q <= sync_q[MSB];
    end
  end

  assign rise = sync_q[MSB] & ~hist_q;
  assign fall = ~sync_q[MSB] & hist_q;

endmodule

// File: rtl/tcs_src_mux.sv
module tcs_src_mux
  import tcs_pkg::*;
#(
  parameter int NUM_TAPS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          sel,
  input  logic [NUM_TAPS-1:0] roll,
  input  logic                rise,
  input  logic                fall,
  output logic                tick
);

  logic nxt;

  always_comb begin
    unique case (src_sel_e'(sel))
      SRC_OFF:      nxt = 1'b0;
      SRC_DIV1:     nxt = 1'b1;
      SRC_DIV8:     nxt = roll[0];
      SRC_DIV32:    nxt = roll[1];
      SRC_DIV256:   nxt = roll[2];
      SRC_DIV1024:  nxt = roll[3];
      SRC_EXT_FALL: nxt = fall;
      SRC_EXT_RISE: nxt = rise;
      default:      nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= nxt;
  end

endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tcs_pkg::*;
#(
  parameter int PRESC_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       presc_clr,
  input  logic [2:0] src_sel,
  input  logic       ext_pin,
  output logic       tick
);

  logic [NUM_TAPS-1:0] roll;
  logic                ext_rise;
  logic                ext_fall;

  tcs_prescaler #(
    .CNT_W   (PRESC_W),
    .NUM_TAPS(NUM_TAPS),
    .TAP_LOG ('{3, 5, 8, 10})
  ) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (presc_clr),
    .roll (roll)
  );

  tcs_ext_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_pin),
    .rise (ext_rise),
    .fall (ext_fall)
  );

  tcs_src_mux #(
    .NUM_TAPS(NUM_TAPS)
  ) u_mux (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (src_sel),
    .roll (roll),
    .rise (ext_rise),
    .fall (ext_fall),
    .tick (tick)
  );

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker
  import tcs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       presc_clr,
  input logic [2:0] src_sel,
  input logic       tick
);

  p_stop_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_sel) == SRC_OFF) |-> !tick);

  p_every_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(src_sel) == SRC_DIV1) |-> tick);

  p_div_one_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && src_sel == SRC_DIV8 && $past(src_sel) == SRC_DIV8) |=> !tick);

  p_clear_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(presc_clr) && src_sel == SRC_DIV8 && $past(src_sel) == SRC_DIV8) |=> !tick);

  p_ext_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && src_sel == SRC_EXT_RISE && $past(src_sel) == SRC_EXT_RISE) |=> !tick);

  p_reset_low_r9: assert property (@(posedge clk)
    (!rst_n) |-> !tick);

endmodule

bind tmr_clk_sel tcs_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .presc_clr(presc_clr),
  .src_sel  (src_sel),
  .tick     (tick)
);

// File: tb/tmr_clk_sel_tb.sv
module tmr_clk_sel_tb;
  import tcs_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       presc_clr = 1'b0;
  logic [2:0] src_sel = SRC_DIV1;
  logic       ext_pin = 1'b0;
  logic       tick;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tmr_clk_sel u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .presc_clr(presc_clr),
    .src_sel  (src_sel),
    .ext_pin  (ext_pin),
    .tick     (tick)
  );

  typedef struct packed {
    logic [2:0] sel;
    logic [31:0] win;
    logic [31:0] cnt;
    logic [31:0] first;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 32'd100,  32'd0,  32'd0},    // R1
    '{3'd1, 32'd50,   32'd50, 32'd1},    // R2
    '{3'd2, 32'd64,   32'd8,  32'd8},    // R3 R5
    '{3'd3, 32'd128,  32'd4,  32'd32},   // R3 R5
    '{3'd4, 32'd1024, 32'd4,  32'd256},  // R4 R5
    '{3'd5, 32'd2048, 32'd2,  32'd1024}  // R4 R5
  };
  localparam string VEC_REQ [6] = '{"R1", "R2", "R3", "R3", "R4", "R4"};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (tick) n++;
    end
  endtask

  // Drive one pin transition, then return a 4-bit picture of tick over
  // the next four cycles (oldest sample in the high bit).
  task automatic edge_shape(input logic lvl, output int shape);
    ext_pin = lvl;
    shape = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      shape = (shape << 1) | int'(tick);
    end
  endtask

  initial begin
    int n;
    int first;
    int shape;

    // R9: reset holds the output low
    repeat (4) @(negedge clk);
    chk(tick == 1'b0, "R9", int'(tick), 0);
    rst_n = 1'b1;
    src_sel = SRC_OFF;
    @(negedge clk);
    chk(tick == 1'b0, "R9", int'(tick), 0);

    // Table walk over the stop and prescaled selections
    for (int v = 0; v < 6; v++) begin
      src_sel = VECS[v].sel;
      presc_clr = 1'b1;
      @(negedge clk);
      presc_clr = 1'b0;
      n = 0;
      first = 0;
      for (int c = 1; c <= int'(VECS[v].win); c++) begin
        @(negedge clk);
        if (tick) begin
          n++;
          if (first == 0) first = c;
        end
      end
      chk(n == int'(VECS[v].cnt), VEC_REQ[v], n, int'(VECS[v].cnt));
      chk(first == int'(VECS[v].first), "R5", first, int'(VECS[v].first));
    end

    // R6: rising-edge mode, exact latency
    src_sel = SRC_EXT_RISE;
    ext_pin = 1'b0;
    count_ticks(6, n);
    chk(n == 0, "R8", n, 0);
    edge_shape(1'b1, shape);
    chk(shape == 4'b0010, "R6", shape, 4'b0010);
    // R8: falling edge ignored in rising mode
    ext_pin = 1'b0;
    count_ticks(6, n);
    chk(n == 0, "R8", n, 0);

    // R7: falling-edge mode
    src_sel = SRC_EXT_FALL;
    ext_pin = 1'b1;
    count_ticks(6, n);
    chk(n == 0, "R8", n, 0);
    edge_shape(1'b0, shape);
    chk(shape == 4'b0010, "R7", shape, 4'b0010);

    // R6: burst of ten rising edges, one pulse each
    src_sel = SRC_EXT_RISE;
    count_ticks(4, n);
    first = 0;
    for (int k = 0; k < 10; k++) begin
      ext_pin = 1'b1;
      count_ticks(4, n);
      first += n;
      ext_pin = 1'b0;
      count_ticks(4, n);
      first += n;
    end
    count_ticks(4, n);
    first += n;
    chk(first == 10, "R6", first, 10);

    // R7: burst in falling mode gives ten pulses too
    src_sel = SRC_EXT_FALL;
    count_ticks(4, n);
    first = 0;
    for (int k = 0; k < 10; k++) begin
      ext_pin = 1'b1;
      count_ticks(3, n);
      first += n;
      ext_pin = 1'b0;
      count_ticks(5, n);
      first += n;
    end
    chk(first == 10, "R7", first, 10);

    // R8: prescaler clears and rollovers leave external mode quiet
    src_sel = SRC_EXT_RISE;
    presc_clr = 1'b1;
    @(negedge clk);
    presc_clr = 1'b0;
    count_ticks(1100, n);
    chk(n == 0, "R8", n, 0);

    // R1: stop after activity, including a prescaler clear
    src_sel = SRC_OFF;
    presc_clr = 1'b1;
    @(negedge clk);
    presc_clr = 1'b0;
    count_ticks(40, n);
    chk(n == 0, "R1", n, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(50000 * 4);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule